// File: doc/BRIEF.md
# Reset Strap Bus Mode Controller

This block fixes a processor's external bus configuration from two strap inputs and then gates an optional group of pins to match it. One strap selects a 32-bit or a 64-bit data bus. The other strap selects full-pinout or reduced-pinout operation. Both straps pass through a two-flop synchronizer. The synchronized values are captured on the one clock edge at which the active-low reset is first seen released. The captured values then stay fixed until the next reset release.

Reduced-pinout operation exists to save switching power. When it is selected, the data bus is forced to 32 bits. The optional pin group is also taken out of service. That group is the low data lane, the data parity bits, the address parity bits and the reservation pin. A disabled pin is pulled low in every cycle in which the core asks to drive it, and released in every other cycle. Its input receiver is switched off, so the core reads zero. The two open-drain parity-error outputs are never enabled in this mode. In full-pinout operation every request and every sampled input passes through unchanged.

Top module: `bus_mode_strap_ctrl`

## Requirements
- R1: The mode flags are loaded only on the clock edge at which `rst_n` is sampled high after having been sampled low. Any later strap change leaves the flags unchanged until the next such edge.
- R2: A width strap of 1 at capture sets `mode_w32_o` to 1 (32-bit data bus). A width strap of 0 with the pinout strap at 0 leaves `mode_w32_o` at 0 (64-bit).
- R3: A pinout strap of 1 at capture sets `mode_rp_o` to 1 (reduced pinout). A pinout strap of 0 sets it to 0 (full pinout).
- R4: Whenever `mode_rp_o` is 1, `mode_w32_o` is also 1, whatever the width strap was.
- R5: In full pinout with reset released, for every bit of the optional group:
  - `opt_pad_oe_o` equals `opt_core_oe_i`.
  - `opt_pad_do_o` equals `opt_core_do_i` where the enable is 1, and 0 elsewhere.
  - `opt_rx_en_o` is 1 and `opt_core_di_o` equals `opt_pad_di_i`.
  - `perr_pad_oe_o` equals `perr_core_req_i`.
- R6: In reduced pinout, `opt_pad_oe_o` still equals `opt_core_oe_i` and `opt_pad_do_o` is 0 on every bit, so a pin is pulled low exactly when the core asks to drive it.
- R7: In reduced pinout, both bits of `perr_pad_oe_o` are 0 whatever `perr_core_req_i` is. Bit 0 is the address-parity error and bit 1 is the data-parity error.
- R8: In reduced pinout, `opt_rx_en_o` is 0 and `opt_core_di_o` is 0 whatever `opt_pad_di_i` is.
- R9: While `rst_n` is 0, the following outputs are 0 and the mode flags keep their previous values:
  - `opt_pad_oe_o`, `opt_pad_do_o`, `opt_rx_en_o` and `opt_core_di_o`
  - `perr_pad_oe_o`
- R10: From power-up until the first reset release, the flags read 64-bit, full pinout (`mode_w32_o`=0, `mode_rp_o`=0).
- R11: A strap value is captured only if it was applied at least two clock edges before the release edge. A value applied one edge before the release edge is not captured; the previous value is.
- R12: Bit layout of the optional group (45 bits by default):
  - [31:0]: low data lane
  - [39:32]: data parity
  - [43:40]: address parity
  - [44]: reservation pin

  Every bit is gated by the same rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_w32_i | input | 1 | Data-width strap, 1 selects 32-bit |
| strap_rp_i | input | 1 | Pinout strap, 1 selects reduced pinout |
| opt_core_oe_i | input | 45 | Core drive request per optional pin |
| opt_core_do_i | input | 45 | Core output value per optional pin |
| opt_pad_di_i | input | 45 | Value seen at each optional pad |
| perr_core_req_i | input | 2 | Core pull-low request for the open-drain error outputs |
| opt_pad_do_o | output | 45 | Value driven onto each optional pad |
| opt_pad_oe_o | output | 45 | Pad output enable per optional pin |
| opt_rx_en_o | output | 45 | Input receiver enable per optional pin |
| opt_core_di_o | output | 45 | Sampled pad value returned to the core |
| perr_pad_oe_o | output | 2 | Pull-low enable for the open-drain error outputs |
| mode_w32_o | output | 1 | 1 = 32-bit data bus |
| mode_rp_o | output | 1 | 1 = reduced pinout |

## Verification
The hardest case to reach from the ports is the synchronizer boundary at reset release. There the captured mode depends on exactly how many edges before the release a strap moved. The stimulus holds reset low with stable straps, changes the straps at one chosen falling edge, and releases reset either one or two falling edges later. One release is expected to capture the old value and the other the new value. A second hard case is proving that modes do not change after release. For this, straps are toggled repeatedly while reset stays high, and the flags and pin gating are then re-read through the normal outputs.

// File: rtl/bms_pkg.sv
// Package: shared types for the reset strap bus mode controller.
// Assumes: nothing beyond IEEE 1800-2017.
package bms_pkg;
    // Captured bus configuration.
    typedef struct packed {
        logic w32;  // 1 = 32-bit data bus
        logic rp;   // 1 = reduced pinout
    } bus_mode_t;

    localparam bus_mode_t MODE_POWERUP = '{w32: 1'b0, rp: 1'b0};
endpackage

// File: rtl/bms_strap_sync.sv
// Module: bms_strap_sync
// Multi-stage flop synchronizer for asynchronous strap inputs.
// Assumes: each strap bit is a quasi-static level; no reset, so the chain
// keeps following the pins while the chip reset is asserted.
module bms_strap_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) stg_q[0] <= async_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-times the stage before it.
        always_ff @(posedge clk) stg_q[s] <= stg_q[s-1];
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/bms_mode_latch.sv
// Module: bms_mode_latch
// Captures the synchronized straps on the edge where reset is first seen
// released and holds them until the next release.
// Assumes: rst_n is synchronous active-low. Flags power up to 64-bit,
// full pinout, and are never cleared by reset itself.
module bms_mode_latch
    import bms_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_w32_i,
    input  logic      sync_rp_i,
    output bus_mode_t mode_o
);
    logic      rst_prev_q = 1'b1;
    bus_mode_t mode_q     = MODE_POWERUP;
    logic      capture;

    // Remember the reset level seen at the previous edge.
    always_ff @(posedge clk) rst_prev_q <= rst_n;

    assign capture = rst_n & ~rst_prev_q;

    // Load the mode on the release edge; reduced pinout forces 32-bit.
    always_ff @(posedge clk) begin
        if (capture) begin
            mode_q.w32 <= sync_w32_i | sync_rp_i;
            mode_q.rp  <= sync_rp_i;
        end
    end

    assign mode_o = mode_q;

    // R4
    rp_forces_w32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.rp |-> mode_q.w32);

    // R1
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_prev_q |=> $stable(mode_q));

    // R9
    always_ff @(posedge clk) begin
        if (!rst_n && !rst_prev_q)
            reset_hold_chk: assert (mode_q == $past(mode_q));
    end
endmodule

// File: rtl/bms_pin_gate.sv
// Module: bms_pin_gate
// Per-pin gating of the optional bidirectional group. Full pinout passes
// requests through. Reduced pinout pulls a pin low when the core would drive
// it and turns its receiver off.
// Assumes: run_i is low during reset and forces every pin quiet.
module bms_pin_gate #(
    parameter int W = 45
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         reduced_i,
    input  logic [W-1:0] core_oe_i,
    input  logic [W-1:0] core_do_i,
    input  logic [W-1:0] pad_di_i,
    output logic [W-1:0] pad_do_o,
    output logic [W-1:0] pad_oe_o,
    output logic [W-1:0] rx_en_o,
    output logic [W-1:0] core_di_o
);
    for (genvar b = 0; b < W; b++) begin : g_pin
        logic live;
        logic drive;

        // A pin is in service only out of reset and in full pinout.
        always_comb live = run_i & ~reduced_i;

        // Drive request is honoured out of reset in both modes.
        always_comb drive = run_i & core_oe_i[b];

        // Pad side: enable follows request; data is zeroed when disabled.
        always_comb begin
            pad_oe_o[b] = drive;
            pad_do_o[b] = drive & live & core_do_i[b];
        end

        // Receiver side: sampled only while the pin is in service.
        always_comb begin
            rx_en_o[b]   = live;
            core_di_o[b] = live & pad_di_i[b];
        end
    end

    // R6
    reduced_low_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reduced_i |-> (pad_do_o == '0));

    // R8
    reduced_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reduced_i |-> (core_di_o == '0 && rx_en_o == '0));

    // R9
    always_ff @(posedge clk) begin
        if (!run_i)
            quiet_in_reset_chk: assert (pad_oe_o == '0 && rx_en_o == '0);
    end
endmodule

// File: rtl/bms_od_gate.sv
// Module: bms_od_gate
// Gates the open-drain parity-error outputs. These are three-stated
// throughout reduced pinout and during reset.
// Assumes: an enabled output pulls the pad low; external pull-up.
module bms_od_gate #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         reduced_i,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pad_oe_o
);
    // Pass pull-low requests only in full pinout, out of reset.
    always_comb pad_oe_o = (run_i & ~reduced_i) ? req_i : '0;

    // R7
    od_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reduced_i |-> (pad_oe_o == '0));
endmodule

// File: rtl/bus_mode_strap_ctrl.sv
// Module: bus_mode_strap_ctrl (top)
// Latches the data-width and pinout straps at reset release and gates the
// optional pin group and the open-drain error outputs accordingly.
// Assumes: synchronous active-low reset; straps are static around release.
module bus_mode_strap_ctrl #(
    parameter  int LANE_W = 32,
    parameter  int DPAR_W = 8,
    parameter  int APAR_W = 4,
    parameter  int SYNC_N = 2,
    localparam int OPT_W  = LANE_W + DPAR_W + APAR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_w32_i,
    input  logic             strap_rp_i,
    input  logic [OPT_W-1:0] opt_core_oe_i,
    input  logic [OPT_W-1:0] opt_core_do_i,
    input  logic [OPT_W-1:0] opt_pad_di_i,
    input  logic [1:0]       perr_core_req_i,
    output logic [OPT_W-1:0] opt_pad_do_o,
    output logic [OPT_W-1:0] opt_pad_oe_o,
    output logic [OPT_W-1:0] opt_rx_en_o,
    output logic [OPT_W-1:0] opt_core_di_o,
    output logic [1:0]       perr_pad_oe_o,
    output logic             mode_w32_o,
    output logic             mode_rp_o
);
    import bms_pkg::*;

    logic [1:0] strap_sync;
    bus_mode_t  mode;

    bms_strap_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .async_i ({strap_rp_i, strap_w32_i}),
        .sync_o  (strap_sync)
    );

    bms_mode_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_w32_i (strap_sync[0]),
        .sync_rp_i  (strap_sync[1]),
        .mode_o     (mode)
    );

    bms_pin_gate #(.W(OPT_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (rst_n),
        .reduced_i (mode.rp),
        .core_oe_i (opt_core_oe_i),
        .core_do_i (opt_core_do_i),
        .pad_di_i  (opt_pad_di_i),
        .pad_do_o  (opt_pad_do_o),
        .pad_oe_o  (opt_pad_oe_o),
        .rx_en_o   (opt_rx_en_o),
        .core_di_o (opt_core_di_o)
    );

    bms_od_gate #(.N(2)) u_od (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (rst_n),
        .reduced_i (mode.rp),
        .req_i     (perr_core_req_i),
        .pad_oe_o  (perr_pad_oe_o)
    );

    assign mode_w32_o = mode.w32;
    assign mode_rp_o  = mode.rp;
endmodule

// File: tb/bus_mode_strap_ctrl_bench.sv
// Bench: table of mode/stimulus vectors, then directed reset and strap-timing tests.
module bus_mode_strap_ctrl_bench;
    localparam int W = 45;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         strap_w32 = 1'b0, strap_rp = 1'b0;
    logic [W-1:0] core_oe = '0, core_do = '0, pad_di = '0;
    logic [1:0]   perr_req = '0;
    logic [W-1:0] pad_do, pad_oe, rx_en, core_di;
    logic [1:0]   perr_oe;
    logic         m_w32, m_rp;

    int n_chk = 0;
    int n_bad = 0;

    bus_mode_strap_ctrl u_bus_mode_strap_ctrl (
        .clk(clk), .rst_n(rst_n), .strap_w32_i(strap_w32), .strap_rp_i(strap_rp),
        .opt_core_oe_i(core_oe), .opt_core_do_i(core_do), .opt_pad_di_i(pad_di),
        .perr_core_req_i(perr_req), .opt_pad_do_o(pad_do), .opt_pad_oe_o(pad_oe),
        .opt_rx_en_o(rx_en), .opt_core_di_o(core_di), .perr_pad_oe_o(perr_oe),
        .mode_w32_o(m_w32), .mode_rp_o(m_rp)
    );

    typedef struct packed {
        logic         w32;
        logic         rp;
        logic [W-1:0] oe;
        logic [W-1:0] dout;
        logic [W-1:0] din;
        logic [1:0]   perr;
        logic         exp_w32;
        logic         exp_rp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 45'h1FFF_FFFF_FFFF, 45'h0AAA_5555_AAAA, 45'h1234_5678_9ABC, 2'b11, 1'b0, 1'b0},
        '{1'b1, 1'b0, 45'h1000_FFFF_0000, 45'h1FFF_FFFF_FFFF, 45'h1F0F_0F0F_0F0F, 2'b01, 1'b1, 1'b0},
        '{1'b0, 1'b1, 45'h1FFF_FFFF_FFFF, 45'h1FFF_FFFF_FFFF, 45'h1FFF_FFFF_FFFF, 2'b11, 1'b1, 1'b1},
        '{1'b1, 1'b1, 45'h0F00_0000_00F1, 45'h0F00_0000_00FF, 45'h1555_5555_5555, 2'b10, 1'b1, 1'b1},
        '{1'b0, 1'b0, 45'h0000_0000_0000, 45'h1FFF_FFFF_FFFF, 45'h0000_0000_0001, 2'b10, 1'b0, 1'b0},
        '{1'b1, 1'b0, 45'h1FFF_0000_FFFF, 45'h0123_4567_89AB, 45'h1FFF_FFFF_FFFF, 2'b00, 1'b1, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Checks all pin outputs against a model written from R5-R8.
    task automatic check_pins(input string req, input logic red);
        logic [W-1:0] e_do, e_rx, e_di;
        logic [1:0]   e_perr;
        e_do   = red ? '0 : (core_oe & core_do);
        e_rx   = red ? '0 : '1;
        e_di   = red ? '0 : pad_di;
        e_perr = red ? 2'b00 : perr_req;
        check(req, "pad_oe", 64'(pad_oe), 64'(core_oe));
        check(req, "pad_do", 64'(pad_do), 64'(e_do));
        check(req, "rx_en", 64'(rx_en), 64'(e_rx));
        check(req, "core_di", 64'(core_di), 64'(e_di));
        check(req, "perr_oe", 64'(perr_oe), 64'(e_perr));
    endtask

    // Reset with straps held stable, then release; returns after capture edge.
    task automatic reset_with(input logic w, input logic r);
        @(negedge clk);
        rst_n = 1'b0;
        strap_w32 = w;
        strap_rp = r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R10 / R9: power-up defaults while reset is held, all pins quiet.
        core_oe = '1;
        core_do = '1;
        pad_di = '1;
        perr_req = 2'b11;
        strap_w32 = 1'b1;
        strap_rp = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R10", "w32 powerup", 64'(m_w32), 64'd0);
        check("R10", "rp powerup", 64'(m_rp), 64'd0);
        check("R9", "pad_oe in reset", 64'(pad_oe), 64'd0);
        check("R9", "rx_en in reset", 64'(rx_en), 64'd0);
        check("R9", "core_di in reset", 64'(core_di), 64'd0);
        check("R9", "perr_oe in reset", 64'(perr_oe), 64'd0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R12.
        for (int i = 0; i < NV; i++) begin
            reset_with(VECS[i].w32, VECS[i].rp);
            core_oe = VECS[i].oe;
            core_do = VECS[i].dout;
            pad_di = VECS[i].din;
            perr_req = VECS[i].perr;
            #1;
            check("R2", "mode_w32", 64'(m_w32), 64'(VECS[i].exp_w32));
            check("R3", "mode_rp", 64'(m_rp), 64'(VECS[i].exp_rp));
            if (m_rp) check("R4", "w32 forced", 64'(m_w32), 64'd1);
            check(VECS[i].exp_rp ? "R6" : "R5", "pins", 64'(0), 64'(0));
            check_pins(VECS[i].exp_rp ? "R6_R7_R8" : "R5_R12", VECS[i].exp_rp);
        end

        // R1: straps toggled after release do not alter the mode.
        reset_with(1'b0, 1'b1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            strap_rp = k[0];
            strap_w32 = k[1];
        end
        repeat (3) @(negedge clk);
        #1;
        check("R1", "rp held", 64'(m_rp), 64'd1);
        check("R1", "w32 held", 64'(m_w32), 64'd1);
        core_oe = '1;
        core_do = '1;
        pad_di = '1;
        perr_req = 2'b11;
        #1;
        check_pins("R1", 1'b1);

        // R9: during reset the flags keep the reduced mode and pins go quiet.
        @(negedge clk);
        rst_n = 1'b0;
        strap_rp = 1'b0;
        strap_w32 = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check("R9", "rp held in reset", 64'(m_rp), 64'd1);
        check("R9", "w32 held in reset", 64'(m_w32), 64'd1);
        check("R9", "pad_oe quiet", 64'(pad_oe), 64'd0);
        check("R9", "pad_do quiet", 64'(pad_do), 64'd0);

        // R11: strap change one edge before release is missed.
        @(negedge clk);
        strap_rp = 1'b1;
        strap_w32 = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R11", "late rp missed", 64'(m_rp), 64'd0);
        check("R11", "late w32 missed", 64'(m_w32), 64'd0);

        // R11: change two edges before release is captured.
        @(negedge clk);
        rst_n = 1'b0;
        strap_rp = 1'b0;
        strap_w32 = 1'b0;
        repeat (4) @(negedge clk);
        strap_rp = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R11", "early rp captured", 64'(m_rp), 64'd1);
        check("R11", "early w32 forced", 64'(m_w32), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule